// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Registers

This block holds the interrupt side of a network controller's control space. Single-cycle event pulses from the transmit engine, the receive engine, the bus master and the link monitor are caught in sticky status bits. A bit stays set until software writes a one to its position. The same 32-bit status word also carries two derived summary bits and two read-only fields. These fields show the live state of the transmit and receive processes.

A second word holds the interrupt enable mask. Only positions that name a real source or a summary can be written there; all other positions read back as zero. A single level-sensitive interrupt line is high while any set status bit has its enable bit set. Software reaches both words through a plain 32-bit port. The port has a word select, a write strobe, write data and combinational read data.

Top module: `nic_irq_csr`

## Requirements
- R1: After reset the status word reads 0 apart from the live process-state fields, the enable word reads 0, and `irq` is low.
- R2: A pulse on `evt_pulse[i]` sets one status bit on the next clock edge, and that bit stays set. The mapping from index to bit is: 0→bit 0 (transmit done), 1→bit 1 (transmit stopped), 2→bit 2 (transmit buffer unavailable), 3→bit 5 (transmit underflow), 4→bit 6 (receive done), 5→bit 7 (receive buffer unavailable), 6→bit 8 (receive stopped), 7→bit 13 (fatal bus error), 8→bit 27 (link change).
- R3: A status write (`reg_sel`=0, `reg_we`=1) clears each sticky bit whose position holds a 1 in `reg_wdata`. Positions written as 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is set afterwards.
- R5: Status bits 22:20 show `tx_state` and bits 19:17 show `rx_state` at all times. Writes have no effect on them.
- R6: An enable write (`reg_sel`=1) stores `reg_wdata` only at bits 0,1,2,5,6,7,8,13,15,16,27. All other enable bits read 0. Writing 0 masks every source, so `irq` is low on the next cycle.
- R7: `irq` is high exactly when some sticky status bit is set together with its enable bit at the same position.
- R8: Status bit 16 (normal summary) is the OR of masked bits 0, 2 and 6. Status bit 15 (abnormal summary) is the OR of masked bits 1, 5, 7, 8 and 13. The link change bit feeds neither summary.
- R9: Writing all ones to the status word clears every sticky event bit in one write.
- R10: `reg_rdata` shows the status word when `reg_sel`=0 and the enable word when `reg_sel`=1, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 9 | One-cycle event pulses, index mapping as in R2 |
| tx_state | input | 3 | Live transmit process state, 0 = stopped |
| rx_state | input | 3 | Live receive process state, 0 = stopped |
| reg_sel | input | 1 | Word select: 0 status, 1 enable |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level interrupt request |

## Verification
The checks assume that each event input is a single-cycle pulse sampled on the clock edge. They also assume that the process-state inputs are driven by registered logic and so are stable around the edge. The bench drives every input at the falling edge and holds it through the next rising edge. Event pulses are drawn sparse at random, and are sometimes deliberately set to collide with a clearing write. Writes use random data over the full 32 bits, so the reserved, summary and state positions are all exercised without breaking these assumptions.

// File: rtl/nic_irq_pkg.sv
// Shared constants for the interrupt status/enable register block.
// Assumes a 32-bit register word and a fixed event-to-bit layout that
// software decodes; only the layout positions are fixed, all masks derive.
package nic_irq_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_EVT = 9;
    localparam int unsigned STATE_W = 3;

    // Status/enable bit position of each event index.
    localparam int unsigned EVT_POS [NUM_EVT] = '{0, 1, 2, 5, 6, 7, 8, 13, 27};

    // Summary and process-state positions.
    localparam int unsigned NSUM_POS = 16;
    localparam int unsigned ASUM_POS = 15;
    localparam int unsigned RXST_LO  = 17;
    localparam int unsigned TXST_LO  = RXST_LO + STATE_W;

    // Event indices that feed each summary bit.
    localparam logic [NUM_EVT-1:0] NORMAL_SET   = 9'b0_0001_0101;
    localparam logic [NUM_EVT-1:0] ABNORMAL_SET = 9'b0_1110_1010;

    // Build the mask of writable enable positions.
    function automatic logic [DATA_W-1:0] enable_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EVT; i++) m[EVT_POS[i]] = 1'b1;
        m[NSUM_POS] = 1'b1;
        m[ASUM_POS] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] EN_MASK = enable_mask();
endpackage

// File: rtl/nic_irq_sticky.sv
// Sticky event latches, one per event source.
// A bit sets on its pulse and clears on its clear strobe; a pulse wins
// over a clear in the same cycle. Assumes pulses are synchronous to clk.
module nic_irq_sticky #(
    parameter int unsigned N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // Hold, clear on write-one, set on event (set has priority).
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/nic_irq_summary.sv
// Combines sticky bits with their enables into the two summary flags
// and the interrupt request. Purely combinational; assumes its inputs
// come straight from registers.
module nic_irq_summary
    import nic_irq_pkg::*;
(
    input  logic [NUM_EVT-1:0] sticky_i,
    input  logic [NUM_EVT-1:0] en_evt_i,
    input  logic               en_norm_i,
    input  logic               en_abn_i,
    output logic               norm_o,
    output logic               abn_o,
    output logic               irq_o
);
    logic [NUM_EVT-1:0] masked;

    // Mask events and reduce into summaries and the request line.
    always_comb begin
        masked = sticky_i & en_evt_i;
        norm_o = |(masked & NORMAL_SET);
        abn_o  = |(masked & ABNORMAL_SET);
        irq_o  = (|masked) | (norm_o & en_norm_i) | (abn_o & en_abn_i);
    end
endmodule

// File: rtl/nic_irq_csr.sv
// Interrupt status and enable register pair of a network controller.
// Status: sticky write-one-to-clear event bits, derived summaries and
// read-only live process-state fields. Enable: masked storage of the
// writable positions. Drives one level interrupt. Assumes a single
// synchronous register port with combinational read data.
module nic_irq_csr
    import nic_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [STATE_W-1:0] tx_state,
    input  logic [STATE_W-1:0] rx_state,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    logic [DATA_W-1:0]  en_q;
    logic [NUM_EVT-1:0] sticky_q;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] en_evt;
    logic               norm_sum;
    logic               abn_sum;
    logic [DATA_W-1:0]  status_word;
    logic               stat_wr;

    assign stat_wr = reg_we & ~reg_sel;

    // Gather per-event clear strobes and enables from their bit positions.
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_map
        assign clr_vec[g] = stat_wr & reg_wdata[EVT_POS[g]];
        assign en_evt[g]  = en_q[EVT_POS[g]];
    end

    // Enable register: store writable positions only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (reg_we && reg_sel)
            en_q <= reg_wdata & EN_MASK;
    end

    nic_irq_sticky #(.N(NUM_EVT)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse),
        .clr_i (clr_vec),
        .q_o   (sticky_q)
    );

    nic_irq_summary u_summary (
        .sticky_i  (sticky_q),
        .en_evt_i  (en_evt),
        .en_norm_i (en_q[NSUM_POS]),
        .en_abn_i  (en_q[ASUM_POS]),
        .norm_o    (norm_sum),
        .abn_o     (abn_sum),
        .irq_o     (irq)
    );

    // Assemble the status word from sticky bits, summaries and live states.
    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_EVT; i++) status_word[EVT_POS[i]] = sticky_q[i];
        status_word[NSUM_POS] = norm_sum;
        status_word[ASUM_POS] = abn_sum;
        status_word[RXST_LO +: STATE_W] = rx_state;
        status_word[TXST_LO +: STATE_W] = tx_state;
    end

    // Read mux for the selected word.
    assign reg_rdata = reg_sel ? en_q : status_word;
endmodule

// File: rtl/nic_irq_csr_chk.sv
// Temporal checks for nic_irq_csr, attached with bind. Assumes event
// inputs are one-cycle pulses and the reset is held for at least one edge.
module nic_irq_csr_chk
    import nic_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic [STATE_W-1:0] tx_state,
    input logic [STATE_W-1:0] rx_state,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq,
    input logic [NUM_EVT-1:0] sticky_q
);
    logic [NUM_EVT-1:0] wr_ones;
    always_comb begin
        for (int i = 0; i < NUM_EVT; i++)
            wr_ones[i] = reg_we && !reg_sel && reg_wdata[EVT_POS[i]];
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((sticky_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R3
    no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sticky_q) & ~sticky_q) & ~$past(wr_ones)) == '0));

    // R4
    collide_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & wr_ones)) |=> ((sticky_q & $past(evt_pulse & wr_ones)) != '0));

    // R5
    state_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[TXST_LO +: STATE_W] == tx_state &&
                      reg_rdata[RXST_LO +: STATE_W] == rx_state));

    // R6
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel && reg_wdata == '0) |=> !irq);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt_pulse) || $past(reg_we && reg_sel)));
endmodule

bind nic_irq_csr nic_irq_csr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .tx_state  (tx_state),
    .rx_state  (rx_state),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .sticky_q  (sticky_q)
);

// File: tb/nic_irq_csr_bench.sv
`timescale 1ns/100ps
module nic_irq_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  evt_pulse;
    logic [2:0]  tx_state, rx_state;
    logic        reg_sel, reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Bench-side model, built from the requirements.
    int unsigned pos [9] = '{0, 1, 2, 5, 6, 7, 8, 13, 27};
    logic [8:0]  m_sticky;
    logic [31:0] m_en;
    localparam logic [31:0] WR_MASK = 32'h0801_A1E7;

    always #2 clk = ~clk;

    nic_irq_csr u_nic_irq_csr (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .tx_state(tx_state), .rx_state(rx_state), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [8:0] en_of(logic [31:0] e);
        logic [8:0] r;
        for (int i = 0; i < 9; i++) r[i] = e[pos[i]];
        return r;
    endfunction

    function automatic logic [31:0] exp_status(logic [8:0] s, logic [31:0] e,
                                               logic [2:0] tx, logic [2:0] rx);
        logic [31:0] w;
        logic [8:0]  m;
        m = s & en_of(e);
        w = '0;
        for (int i = 0; i < 9; i++) w[pos[i]] = s[i];
        w[16] = m[0] | m[2] | m[4];
        w[15] = m[1] | m[3] | m[5] | m[6] | m[7];
        w[22:20] = tx;
        w[19:17] = rx;
        return w;
    endfunction

    function automatic logic exp_irq(logic [8:0] s, logic [31:0] e);
        return |(s & en_of(e));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model at rising edge.
    task automatic step(logic [8:0] ev, logic we, logic sel, logic [31:0] wd);
        logic [8:0] clr;
        @(negedge clk);
        evt_pulse = ev; reg_we = we; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < 9; i++) clr[i] = we && !sel && wd[pos[i]];
        m_sticky = (m_sticky & ~clr) | ev;
        if (we && sel) m_en = wd & WR_MASK;
        #0.5;
        evt_pulse = '0; reg_we = 1'b0;
    endtask

    // Read the selected word right after an edge and compare.
    task automatic peek(string req, logic sel);
        reg_sel = sel;
        #0.5;
        check(req, reg_rdata, sel ? m_en : exp_status(m_sticky, m_en, tx_state, rx_state));
        check({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq(m_sticky, m_en)});
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; evt_pulse = '0; reg_we = 0; reg_sel = 0; reg_wdata = '0;
        tx_state = 3'd0; rx_state = 3'd0;
        m_sticky = '0; m_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tx_state = 3'd5; rx_state = 3'd2;
        // R1: reset state of both words and irq
        #0.5; peek("R1 status", 1'b0); peek("R1 enable", 1'b1);

        // R2: link change event lands on bit 27 and sticks
        step(9'h100, 0, 0, '0); peek("R2 link set", 1'b0);
        step(9'h000, 0, 0, '0);
        check("R2 link held", reg_rdata[27], 1'b1);

        // R7/R8: enable link only -> irq, summaries stay low
        step('0, 1, 1, 32'h0800_0000); peek("R7 link irq", 1'b0);
        check("R8 link not in summaries", {30'd0, reg_rdata[16:15]}, 32'd0);

        // R8: rx done normal, underflow abnormal with full enable
        step(9'h018, 1, 1, 32'hFFFF_FFFF); peek("R6 enable masked readback", 1'b1);
        peek("R8 summaries", 1'b0);

        // R3: clear only bit 6, keep others
        step('0, 1, 0, 32'h0000_0040); peek("R3 partial clear", 1'b0);

        // R4: clear and event on bit 5 together
        step(9'h008, 1, 0, 32'h0000_0020); peek("R4 collide", 1'b0);

        // R5: writes to state fields ignored
        step('0, 1, 0, 32'h0070_0000 | 32'h000E_0000); peek("R5 state ro", 1'b0);
        tx_state = 3'd0; rx_state = 3'd7; peek("R5 state live", 1'b0);

        // R6: write 0 to enable masks everything
        step('0, 1, 1, 32'h0); peek("R6 mask all", 1'b0);
        check("R6 irq low", {31'd0, irq}, 32'd0);

        // R9: all ones clears every event
        step(9'h1FF, 0, 0, '0);
        step('0, 1, 0, 32'hFFFF_FFFF); peek("R9 clear all", 1'b0);

        // R10: random mix, read both words
        for (int n = 0; n < 400; n++) begin
            logic [8:0]  ev;
            logic        we, sel;
            logic [31:0] wd;
            ev  = 9'($urandom) & 9'($urandom) & 9'($urandom);
            we  = ($urandom % 3) == 0;
            sel = $urandom % 2;
            wd  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            tx_state = 3'($urandom); rx_state = 3'($urandom);
            step(ev, we, sel, wd);
            peek("R10 random", 1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule